// File: doc/BRIEF.md
# Serial flash erase command engine

This block is the device-side command logic of a small serial NOR flash that deals only with erasing. It listens on a single-bit SPI bus in mode 0 (chip select active low, input sampled on rising SCLK, output changed on falling SCLK). The bus pins are sampled by the block's own system clock through two-stage synchronisers, so SCLK must be several system clocks slower than `clk`. It decodes a write enable, a status read, two block erase sizes (32 KB and 64 KB) and chip erase. The memory array sits outside the block and performs the erase.

The block holds a status byte with a busy flag, a write-enable latch and four protect bits. The protect bits are fixed at reset by a parameter. An erase is accepted only when all of these hold: the latch is set, the frame has exactly the expected number of bits when chip select rises, and the protect bits allow the target region. When an erase is accepted, the block sends the array a one-cycle request carrying the aligned base address and the byte length. It then holds the busy flag for a parameterised number of clock cycles. At the end of that period the busy flag and the latch both clear. The request has no ready signal: the array must accept every pulse, and no second pulse can arrive while the busy flag is set.

Top module: `spi_erase_engine`

## Requirements
- R1: A frame of exactly 8 bits carrying opcode 0x06 sets the write-enable latch, which is status bit 1.
- R2: An erase opcode (0x52, 0xD8, 0x60 or 0xC7) received while the write-enable latch is clear produces no request and leaves the status byte unchanged.
- R3: A block erase (0x52 or 0xD8) acts only if chip select rises after exactly 32 bits (opcode followed by a 24-bit address, MSB first). A chip erase (0x60 or 0xC7) acts only if chip select rises after exactly 8 bits. Any other length produces no request and leaves the latch as it was.
- R4: An accepted erase pulses `erase_req` for one cycle. For 0x52 it gives base = address with bits 14:0 cleared and length 0x8000. For 0xD8 it gives base = address with bits 15:0 cleared and length 0x10000. For chip erase it gives base 0 and length 0x80000. Address bits above bit 18 are ignored.
- R5: From the request cycle, status bit 0 (busy) reads 1 for T_B32, T_B64 or T_CHIP clock cycles, chosen by the erase type. When that period ends, the busy bit and the write-enable latch both read 0.
- R6: While the busy bit is 1, every frame except a status read is ignored. This includes write enable and further erases.
- R7: Opcode 0x05 returns the status byte on `miso`, MSB first, changing on falling SCLK. The byte is repeated for as long as chip select stays low. The layout is bits 7:6 = 0, bits 5:2 = protect value, bit 1 = latch, bit 0 = busy.
- R8: When the protect value P is nonzero, the top 2^(P-1) 64 KB blocks of the 512 KB space are protected (all blocks once 2^(P-1) >= 8). A block erase whose address lies in a protected 64 KB block produces no request.
- R9: Chip erase is accepted only when protect bits 2:0 are all zero.
- R10: After reset, the busy bit and the latch are 0, the protect bits equal RESET_BP, and `miso` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| sclk | input | 1 | SPI serial clock (mode 0) |
| cs_n | input | 1 | SPI chip select, active low |
| mosi | input | 1 | SPI serial data in |
| miso | output | 1 | SPI serial data out, 0 when not reading status |
| erase_req | output | 1 | One-cycle erase request to the array |
| erase_base | output | 19 | Aligned start byte address of the erase |
| erase_len | output | 20 | Erase length in bytes |

## Verification
A wrong latch or busy value appears in the next status byte that is read, one SCLK period after the opcode, and it also shows as a missing request or an extra one on the erase that follows. A wrong bit count or a wrong alignment shows in the same system cycle as the request, as a wrong base, a wrong length or a wrong pulse count, within a few clocks of chip select rising. A busy timer of the wrong length shows as status polls that read busy too long or too briefly, so the busy period is bounded only to the resolution of one status frame. A protection fault shows as a request issued, or not issued, for the chosen block addresses.

// File: rtl/spi_erase_pkg.sv
package spi_erase_pkg;
  localparam logic [7:0] OP_WREN  = 8'h06;
  localparam logic [7:0] OP_RDSR  = 8'h05;
  localparam logic [7:0] OP_BLK32 = 8'h52;
  localparam logic [7:0] OP_BLK64 = 8'hD8;
  localparam logic [7:0] OP_CHIPA = 8'h60;
  localparam logic [7:0] OP_CHIPB = 8'hC7;

  typedef enum logic [1:0] {
    KIND_NONE  = 2'd0,
    KIND_BLK32 = 2'd1,
    KIND_BLK64 = 2'd2,
    KIND_CHIP  = 2'd3
  } erase_kind_e;
endpackage

// File: rtl/sfe_spi_front.sv
module sfe_spi_front
  import spi_erase_pkg::*;
#(
  parameter int FRAME_W = 32,
  parameter int CNT_W   = 6
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               sclk,
  input  logic               cs_n,
  input  logic               mosi,
  input  logic [7:0]         stat,
  output logic               miso,
  output logic               frame_end,
  output logic [CNT_W-1:0]   nbits,
  output logic [FRAME_W-1:0] frame
);
  logic [1:0] s_sclk, s_cs, s_mosi;
  logic sclk_d, cs_d;
  logic rise, fall, cs_rise, active;
  logic [CNT_W-1:0] cnt;
  logic [FRAME_W-1:0] sr;
  logic [FRAME_W-1:0] sr_next;
  logic rd_on;
  logic [2:0] rd_cnt;
  logic [7:0] sh;

  assign rise    = s_sclk[1] & ~sclk_d;
  assign fall    = ~s_sclk[1] & sclk_d;
  assign cs_rise = s_cs[1] & ~cs_d;
  assign active  = ~s_cs[1];
  assign sr_next = {sr[FRAME_W-2:0], s_mosi[1]};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s_sclk <= '0; s_cs <= 2'b11; s_mosi <= '0;
      sclk_d <= 1'b0; cs_d <= 1'b1;
    end else begin
      s_sclk <= {s_sclk[0], sclk};
      s_cs   <= {s_cs[0], cs_n};
      s_mosi <= {s_mosi[0], mosi};
      sclk_d <= s_sclk[1];
      cs_d   <= s_cs[1];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0; sr <= '0; frame_end <= 1'b0; nbits <= '0; frame <= '0;
      rd_on <= 1'b0; rd_cnt <= '0; sh <= '0; miso <= 1'b0;
    end else begin
      frame_end <= cs_rise;
      if (cs_rise) begin
        nbits <= cnt;
        frame <= sr;
      end
      if (!active) begin
        cnt <= '0; rd_on <= 1'b0; rd_cnt <= '0; miso <= 1'b0;
      end else begin
        if (rise) begin
          sr <= sr_next;
          if (cnt != '1) cnt <= cnt + 1'b1;
          if (cnt == CNT_W'(7) && sr_next[7:0] == OP_RDSR) rd_on <= 1'b1;
        end
        if (fall && rd_on) begin
          if (rd_cnt == 3'd0) begin
            miso <= stat[7];
            sh   <= {stat[6:0], 1'b0};
          end else begin
            miso <= sh[7];
            sh   <= {sh[6:0], 1'b0};
          end
          rd_cnt <= rd_cnt + 3'd1;
        end
      end
    end
  end

  // R7: output data only moves after a falling SCLK or when the bus goes idle
  assert_miso_on_fall_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(miso) |-> ($past(fall) || !$past(active)));
  // R3: a frame end always follows a chip select release
  assert_frame_end_on_cs_R3: assert property (@(posedge clk) disable iff (!rst_n)
    frame_end |-> $past(cs_rise));
endmodule

// File: rtl/sfe_protect.sv
module sfe_protect #(
  parameter int ADDR_W = 19
) (
  input  logic [3:0]         bp,
  input  logic [ADDR_W-1:0]  addr,
  output logic               locked
);
  localparam int BLK_W = ADDR_W - 16;
  localparam int NBLK  = 1 << BLK_W;

  logic [BLK_W-1:0] blk;
  assign blk = addr[ADDR_W-1:16];

  always_comb begin
    if (bp == 4'd0)
      locked = 1'b0;
    else if (int'(bp) - 1 >= BLK_W)
      locked = 1'b1;
    else
      locked = (int'(blk) >= NBLK - (1 << (int'(bp) - 1)));
  end
endmodule

// File: rtl/sfe_erase_ctrl.sv
module sfe_erase_ctrl
  import spi_erase_pkg::*;
#(
  parameter int         ADDR_W   = 19,
  parameter int         FRAME_W  = 32,
  parameter int         CNT_W    = 6,
  parameter int         T_B32    = 600,
  parameter int         T_B64    = 800,
  parameter int         T_CHIP   = 1000,
  parameter logic [3:0] RESET_BP = 4'd0
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               frame_end,
  input  logic [CNT_W-1:0]   nbits,
  input  logic [FRAME_W-1:0] frame,
  output logic [7:0]         stat,
  output logic               erase_req,
  output logic [ADDR_W-1:0]  erase_base,
  output logic [ADDR_W:0]    erase_len
);
  localparam int LEN_W = ADDR_W + 1;
  localparam int T_MAX = (T_B32 > T_B64) ? ((T_B32 > T_CHIP) ? T_B32 : T_CHIP)
                                         : ((T_B64 > T_CHIP) ? T_B64 : T_CHIP);
  localparam int TW = $clog2(T_MAX + 1);

  logic wip, wel;
  logic [3:0] bp;
  logic [TW-1:0] tmr;
  logic is8, is32, locked;
  logic [7:0] op8, op32;
  logic [ADDR_W-1:0] addr;
  erase_kind_e kind;
  logic go;
  logic [TW-1:0] dur;
  logic [ADDR_W-1:0] base_n;
  logic [LEN_W-1:0] len_n;

  assign bp   = RESET_BP;
  assign stat = {2'b00, bp, wel, wip};
  assign is8  = (nbits == CNT_W'(8));
  assign is32 = (nbits == CNT_W'(32));
  assign op8  = frame[7:0];
  assign op32 = frame[31:24];
  assign addr = frame[ADDR_W-1:0];

  sfe_protect #(.ADDR_W(ADDR_W)) u_prot (.bp(bp), .addr(addr), .locked(locked));

  always_comb begin
    kind = KIND_NONE;
    if (is32 && op32 == OP_BLK32) kind = KIND_BLK32;
    else if (is32 && op32 == OP_BLK64) kind = KIND_BLK64;
    else if (is8 && (op8 == OP_CHIPA || op8 == OP_CHIPB)) kind = KIND_CHIP;
    unique case (kind)
      KIND_BLK32: begin
        go = wel && !locked; dur = TW'(T_B32 - 1);
        base_n = addr & ~ADDR_W'(32'h7FFF); len_n = LEN_W'(32'h8000);
      end
      KIND_BLK64: begin
        go = wel && !locked; dur = TW'(T_B64 - 1);
        base_n = addr & ~ADDR_W'(32'hFFFF); len_n = LEN_W'(32'h10000);
      end
      KIND_CHIP: begin
        go = wel && (bp[2:0] == 3'd0); dur = TW'(T_CHIP - 1);
        base_n = '0; len_n = LEN_W'(1) << ADDR_W;
      end
      default: begin
        go = 1'b0; dur = '0; base_n = '0; len_n = '0;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wip <= 1'b0; wel <= 1'b0; tmr <= '0;
      erase_req <= 1'b0; erase_base <= '0; erase_len <= '0;
    end else begin
      erase_req <= 1'b0;
      if (wip) begin
        if (tmr == '0) begin
          wip <= 1'b0;
          wel <= 1'b0;
        end else begin
          tmr <= tmr - 1'b1;
        end
      end else if (frame_end) begin
        if (is8 && op8 == OP_WREN) begin
          wel <= 1'b1;
        end else if (go) begin
          wip        <= 1'b1;
          tmr        <= dur;
          erase_req  <= 1'b1;
          erase_base <= base_n;
          erase_len  <= len_n;
        end
      end
    end
  end

  // R4: a request opens a fresh busy period
  assert_req_starts_busy_R4: assert property (@(posedge clk) disable iff (!rst_n)
    erase_req |-> (wip && !$past(wip)));
  // R4: the base is aligned to the length
  assert_base_aligned_R4: assert property (@(posedge clk) disable iff (!rst_n)
    erase_req |-> ((erase_base & ADDR_W'(erase_len - 1'b1)) == '0));
  // R5: the end of busy leaves the latch clear
  assert_done_clears_wel_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(wip) |-> !wel);
  // R2: a request needs the latch set in the cycle before
  assert_req_needs_wel_R2: assert property (@(posedge clk) disable iff (!rst_n)
    erase_req |-> $past(wel));
  // R6: the request outputs hold still during busy
  assert_busy_holds_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (wip && $past(wip)) |-> ($stable(erase_base) && $stable(erase_len)));
  // R9: chip-sized requests only with low protect bits clear
  assert_chip_unprotected_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (erase_req && erase_len == (LEN_W'(1) << ADDR_W)) |-> (bp[2:0] == 3'd0));
endmodule

// File: rtl/spi_erase_engine.sv
module spi_erase_engine #(
  parameter int         ADDR_W   = 19,
  parameter int         T_B32    = 600,
  parameter int         T_B64    = 800,
  parameter int         T_CHIP   = 1000,
  parameter logic [3:0] RESET_BP = 4'd0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sclk,
  input  logic              cs_n,
  input  logic              mosi,
  output logic              miso,
  output logic              erase_req,
  output logic [ADDR_W-1:0] erase_base,
  output logic [ADDR_W:0]   erase_len
);
  localparam int FRAME_W = 32;
  localparam int CNT_W   = 6;

  logic [7:0] stat;
  logic frame_end;
  logic [CNT_W-1:0] nbits;
  logic [FRAME_W-1:0] frame;

  sfe_spi_front #(.FRAME_W(FRAME_W), .CNT_W(CNT_W)) u_front (
    .clk(clk), .rst_n(rst_n), .sclk(sclk), .cs_n(cs_n), .mosi(mosi),
    .stat(stat), .miso(miso), .frame_end(frame_end), .nbits(nbits), .frame(frame)
  );

  sfe_erase_ctrl #(
    .ADDR_W(ADDR_W), .FRAME_W(FRAME_W), .CNT_W(CNT_W),
    .T_B32(T_B32), .T_B64(T_B64), .T_CHIP(T_CHIP), .RESET_BP(RESET_BP)
  ) u_ctrl (
    .clk(clk), .rst_n(rst_n), .frame_end(frame_end), .nbits(nbits), .frame(frame),
    .stat(stat), .erase_req(erase_req), .erase_base(erase_base), .erase_len(erase_len)
  );
endmodule

// File: tb/tb_spi_erase_engine.sv
`timescale 1ns/1ps
module tb_spi_erase_engine;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sclk = 1'b0, mosi = 1'b0, cs_a = 1'b1, cs_b = 1'b1;
  logic miso_a, miso_b, req_a, req_b;
  logic [18:0] base_a, base_b;
  logic [19:0] len_a, len_b;
  int checks = 0, errors = 0;
  int cnt_a = 0, cnt_b = 0, pulse_bad = 0;
  logic [18:0] lb_a, lb_b;
  logic [19:0] ll_a, ll_b;
  logic prev_a = 1'b0, prev_b = 1'b0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  spi_erase_engine #(.RESET_BP(4'd0)) dut (
    .clk(clk), .rst_n(rst_n), .sclk(sclk), .cs_n(cs_a), .mosi(mosi), .miso(miso_a),
    .erase_req(req_a), .erase_base(base_a), .erase_len(len_a));
  spi_erase_engine #(.RESET_BP(4'd2)) dut_p (
    .clk(clk), .rst_n(rst_n), .sclk(sclk), .cs_n(cs_b), .mosi(mosi), .miso(miso_b),
    .erase_req(req_b), .erase_base(base_b), .erase_len(len_b));

  always @(posedge clk) begin
    if (req_a) begin cnt_a <= cnt_a + 1; lb_a <= base_a; ll_a <= len_a; end
    if (req_b) begin cnt_b <= cnt_b + 1; lb_b <= base_b; ll_b <= len_b; end
    if ((req_a && prev_a) || (req_b && prev_b)) pulse_bad <= pulse_bad + 1;
    prev_a <= req_a; prev_b <= req_b;
  end

  typedef struct packed {
    logic [7:0]  op;
    logic [23:0] addr;
    logic [7:0]  nb;
    logic        acc;
    logic [18:0] base;
    logic [19:0] len;
  } vec_t;

  localparam vec_t VECS [8] = '{
    '{8'h52, 24'h012345, 8'd32, 1'b1, 19'h10000, 20'h08000},
    '{8'hD8, 24'h07ABCD, 8'd32, 1'b1, 19'h70000, 20'h10000},
    '{8'h60, 24'h000000, 8'd8,  1'b1, 19'h00000, 20'h80000},
    '{8'hC7, 24'h000000, 8'd8,  1'b1, 19'h00000, 20'h80000},
    '{8'hD8, 24'hF9FFFF, 8'd32, 1'b1, 19'h10000, 20'h10000},
    '{8'h52, 24'h012345, 8'd31, 1'b0, 19'h00000, 20'h00000},
    '{8'h52, 24'h012345, 8'd40, 1'b0, 19'h00000, 20'h00000},
    '{8'h60, 24'h000000, 8'd16, 1'b0, 19'h00000, 20'h00000}
  };

  task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got 0x%0h expected 0x%0h", tag, got, exp);
    end
  endtask

  task automatic spi_frame(input int sel, input logic [39:0] d, input int nb,
                           output logic [15:0] rd);
    rd = '0;
    if (sel == 0) cs_a = 1'b0; else cs_b = 1'b0;
    #80;
    for (int i = 0; i < nb; i++) begin
      mosi = d[39-i];
      #40;
      if (i >= 8 && i < 24) rd[23-i] = (sel == 0) ? miso_a : miso_b;
      sclk = 1'b1;
      #40;
      sclk = 1'b0;
    end
    #40;
    if (sel == 0) cs_a = 1'b1; else cs_b = 1'b1;
    mosi = 1'b0;
    #200;
  endtask

  task automatic send(input int sel, input logic [7:0] op, input logic [23:0] addr, input int nb);
    logic [15:0] rd;
    spi_frame(sel, {op, addr, 8'h00}, nb, rd);
  endtask

  task automatic read_status(input int sel, output logic [7:0] st);
    logic [15:0] rd;
    spi_frame(sel, {8'h05, 32'h0}, 16, rd);
    st = rd[15:8];
  endtask

  task automatic wait_idle(input int sel, output logic [7:0] st);
    for (int k = 0; k < 40; k++) begin
      read_status(sel, st);
      if (st[0] == 1'b0) break;
    end
  endtask

  initial begin
    #1_000_000;
    if (!finished) begin
      errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [7:0] st;
    logic [15:0] rd;
    int c0;
    #50 rst_n = 1'b1;
    #50;
    // R10: reset state
    check("R10 miso idle", {31'd0, miso_a}, 32'd0);
    read_status(0, st); check("R10 status dut", {24'd0, st}, 32'h00);
    read_status(1, st); check("R10 status dut_p", {24'd0, st}, 32'h08);
    // R2: erase without the latch
    send(0, 8'hD8, 24'h000000, 32); #100;
    check("R2 no request", cnt_a, 0);
    read_status(0, st); check("R2 status", {24'd0, st}, 32'h00);
    // R1 and R7: latch set, repeated status byte
    send(0, 8'h06, 24'h0, 8);
    spi_frame(0, {8'h05, 32'h0}, 24, rd);
    check("R1 latch set", {24'd0, rd[15:8]}, 32'h02);
    check("R7 repeat byte", {24'd0, rd[7:0]}, 32'h02);

    // vector table walk on the unprotected instance
    foreach (VECS[v]) begin
      send(0, 8'h06, 24'h0, 8);
      c0 = cnt_a;
      send(0, VECS[v].op, VECS[v].addr, int'(VECS[v].nb));
      #100;
      if (VECS[v].acc) begin
        check($sformatf("R4 vec%0d count", v), cnt_a, c0 + 1);
        check($sformatf("R4 vec%0d base", v), {13'd0, lb_a}, {13'd0, VECS[v].base});
        check($sformatf("R4 vec%0d len", v), {12'd0, ll_a}, {12'd0, VECS[v].len});
        read_status(0, st); check($sformatf("R5 vec%0d busy", v), {24'd0, st}, 32'h03);
        wait_idle(0, st); check($sformatf("R5 vec%0d done", v), {24'd0, st}, 32'h00);
      end else begin
        check($sformatf("R3 vec%0d no request", v), cnt_a, c0);
        read_status(0, st); check($sformatf("R3 vec%0d latch kept", v), {24'd0, st}, 32'h02);
      end
    end

    // R6: frames ignored while busy
    send(0, 8'h06, 24'h0, 8);
    send(0, 8'hC7, 24'h0, 8);
    c0 = cnt_a;
    send(0, 8'hD8, 24'h020000, 32);
    send(0, 8'h06, 24'h0, 8);
    #100;
    check("R6 erase ignored when busy", cnt_a, c0);
    wait_idle(0, st);
    check("R6 wren ignored when busy", {24'd0, st}, 32'h00);

    // R8: protect value 2 locks blocks 6 and 7
    send(1, 8'h06, 24'h0, 8);
    send(1, 8'hD8, 24'h070000, 32); #100;
    check("R8 block7 locked", cnt_b, 0);
    send(1, 8'h52, 24'h068000, 32); #100;
    check("R8 block6 locked", cnt_b, 0);
    // R9: chip erase refused with protect bits set
    send(1, 8'h60, 24'h0, 8); #100;
    check("R9 chip refused", cnt_b, 0);
    read_status(1, st); check("R9 status kept", {24'd0, st}, 32'h0A);
    send(1, 8'hD8, 24'h05FFFF, 32); #100;
    check("R8 block5 open", cnt_b, 1);
    check("R8 block5 base", {13'd0, lb_b}, 32'h50000);
    wait_idle(1, st); check("R5 dut_p done", {24'd0, st}, 32'h08);

    check("R4 single-cycle pulses", pulse_bad, 0);
    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule